// File: doc/BRIEF.md
# Quasi-Resonant Switch Timing Controller

This block times the gate pulse of a primary-side-regulated flyback or buck-boost power stage. A pulse begins at a switching instant and ends when a comparator reports that the sensed switch current has passed the peak target, subject to leading-edge blanking and fixed minimum and maximum conduction times. After turn-off the block waits for the auxiliary winding to ring down below the zero-current threshold, ignoring that comparator for a fixed interval after turn-off so that switching ringing is not taken as demagnetization. The next pulse starts on the valley (quasi-resonant turn-on), never sooner than the minimum switching period and never later than the maximum one.

For every completed cycle the block reports how long the switch conducted and how long the winding took to demagnetize, so that a charge-regulation loop can compute the next peak target. The peak target code is captured at each pulse start and held steady for the comparator reference during the whole pulse. All limits are counted in clock cycles; the defaults assume a 100 MHz clock (55 cycles of blanking and minimum on-time, 1280 cycles of maximum on-time, 200 cycles of ZCD blanking, a 500-cycle minimum period and a 16667-cycle maximum period).

The control state machine has four states. Idle: gate low, all timers cleared. Conduct: gate high. Demag: gate low, waiting for an unblanked valley. Hold: valley found, waiting for the minimum period to elapse. Transitions: Idle to Conduct when enabled; Conduct to Demag on a valid sense trip past the minimum on-time, or at the maximum on-time; Demag to Conduct on a valley once the minimum period is met, or when the maximum period expires; Demag to Hold on a valley before the minimum period; Hold to Conduct when the minimum period is met; any state to Idle when the enable is low.

Top module: `qr_switch_ctrl`

## Requirements
- R1: While reset is asserted and on the first cycle after it, gate, cycle_done, on_time, demag_time and peak_ref are all zero.
- R2: With en low the gate goes low at the next clock edge, timers return to idle and no cycle_done is produced; when en is seen high in Idle the gate rises at that edge, and this first pulse after enabling produces no cycle_done.
- R3: The sense comparator is ignored during the first BLANK_CYC (55) gate-high cycles, counted from 0 at the first high cycle; a sense pulse confined to that window does not end the pulse.
- R4: A pulse whose first unblanked sense-high cycle has index k (k at least 55) is 55-or-more cycles long and lasts exactly k+1 cycles, with the gate falling at the edge that ends cycle k.
- R5: No pulse ended by sense is shorter than MIN_ON_CYC (55) cycles; with sense held high from the start the pulse lasts 56 cycles.
- R6: With no sense trip the gate is forced low after exactly MAX_ON_CYC (1280) high cycles.
- R7: The ZCD comparator is ignored during the first ZCD_BLANK_CYC (200) gate-low cycles after turn-off, indexed from 0.
- R8: demag_time equals the index plus one of the first gate-low cycle with an unblanked ZCD; it is 0 when no valley arrived before the next start.
- R9: The rise-to-rise period is never below MIN_PERIOD_CYC (500); an early valley waits in Hold until the period reaches 500 cycles.
- R10: A valley seen after the minimum period starts the next pulse at the edge that ends the valley cycle, so the period is on-time plus demag_time.
- R11: Without a valley the next pulse is forced exactly MAX_PERIOD_CYC (16667) cycles after the previous rise.
- R12: cycle_done is high for exactly one cycle, coincident with the first high cycle of the next pulse, and carries on_time and demag_time of the cycle just ended.
- R13: peak_ref takes the value of peak_code at each pulse start and does not change while the gate stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, counts all timing limits |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Switching enable |
| sense_over | input | 1 | High when sensed switch current exceeds the peak target |
| zcd_low | input | 1 | High when the auxiliary winding is below the zero-current threshold |
| peak_code | input | PEAK_W (8) | Peak current target for the next pulse |
| gate | output | 1 | Gate drive for the power switch |
| peak_ref | output | PEAK_W (8) | Peak target captured at pulse start |
| cycle_done | output | 1 | One-cycle strobe at the start of a pulse that follows a full cycle |
| on_time | output | ON_W (11) | Conduction cycles of the finished cycle |
| demag_time | output | PER_W (15) | Demagnetization cycles of the finished cycle, 0 if none seen |

## Verification
The bound checker watches every cycle for the conduction-length limits, the rise-to-rise period limits, the one-cycle strobe aligned with a gate rise, the gate dropping after the enable falls, and peak_ref holding still during a pulse. What only the scenarios can show is the exact cycle of turn-off against a given sense pattern, that blanked sense and ZCD pulses truly have no effect, the exact demagnetization count, the forced restart when no valley comes, and the absence of a strobe after re-enabling; a behavioural model compared on every clock covers all outputs across those scenarios.

// File: rtl/qrs_pkg.sv
package qrs_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_CONDUCT = 2'd1,
        ST_DEMAG   = 2'd2,
        ST_HOLD    = 2'd3
    } qrs_state_e;

endpackage

// File: rtl/qrs_on_timer.sv
// Conduction timer: blanking of the sense comparator, minimum and maximum
// on-time, and capture of the finished pulse width.
module qrs_on_timer #(
    parameter int BLANK_CYC  = 55,
    parameter int MIN_ON_CYC = 55,
    parameter int MAX_ON_CYC = 1280,
    parameter int W          = 11
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         run,
    input  logic         sense,
    output logic         off_req,
    output logic [W-1:0] width_q
);

    localparam logic [W-1:0] BLANK_C = W'(BLANK_CYC);
    localparam logic [W-1:0] MINON_C = W'(MIN_ON_CYC);
    localparam logic [W-1:0] MAXON_C = W'(MAX_ON_CYC);

    logic [W-1:0] cnt_q;
    logic [W-1:0] len;
    logic         trip_q;
    logic         sense_ok;

    always_comb begin
        len      = cnt_q + 1'b1;
        sense_ok = sense && (cnt_q >= BLANK_C);
        off_req  = run && ((((trip_q || sense_ok)) && (len >= MINON_C)) ||
                           (len >= MAXON_C));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            trip_q  <= 1'b0;
            width_q <= '0;
        end else if (clr) begin
            cnt_q  <= '0;
            trip_q <= 1'b0;
        end else if (run) begin
            if (sense_ok) begin
                trip_q <= 1'b1;
            end
            if (off_req) begin
                width_q <= len;
            end else begin
                cnt_q <= len;
            end
        end
    end

endmodule

// File: rtl/qrs_demag_timer.sv
// Off-time timer: ZCD blanking after turn-off and demagnetization count.
module qrs_demag_timer #(
    parameter int ZCD_BLANK_CYC = 200,
    parameter int W             = 15
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         run,
    input  logic         zcd,
    output logic         valley,
    output logic [W-1:0] demag_now
);

    localparam logic [W-1:0] ZB_C = W'(ZCD_BLANK_CYC);

    logic [W-1:0] cnt_q;
    logic [W-1:0] dm_q;
    logic [W-1:0] len;

    always_comb begin
        len       = cnt_q + 1'b1;
        valley    = run && zcd && (cnt_q >= ZB_C);
        demag_now = valley ? len : dm_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            dm_q  <= '0;
        end else if (clr) begin
            cnt_q <= '0;
            dm_q  <= '0;
        end else if (run) begin
            cnt_q <= len;
            if (valley) begin
                dm_q <= len;
            end
        end
    end

endmodule

// File: rtl/qrs_period_timer.sv
// Rise-to-rise period timer: minimum and maximum switching period.
module qrs_period_timer #(
    parameter int MIN_PERIOD_CYC = 500,
    parameter int MAX_PERIOD_CYC = 16667,
    parameter int W              = 15
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic run,
    output logic min_ok,
    output logic force_start
);

    localparam logic [W-1:0] MINP_C = W'(MIN_PERIOD_CYC);
    localparam logic [W-1:0] MAXP_C = W'(MAX_PERIOD_CYC);

    logic [W-1:0] cnt_q;
    logic [W-1:0] len;

    always_comb begin
        len         = cnt_q + 1'b1;
        min_ok      = len >= MINP_C;
        force_start = len >= MAXP_C;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (run && !force_start) begin
            cnt_q <= len;
        end
    end

endmodule

// File: rtl/qr_switch_ctrl.sv
module qr_switch_ctrl
    import qrs_pkg::*;
#(
    parameter int BLANK_CYC      = 55,
    parameter int MIN_ON_CYC     = 55,
    parameter int MAX_ON_CYC     = 1280,
    parameter int ZCD_BLANK_CYC  = 200,
    parameter int MIN_PERIOD_CYC = 500,
    parameter int MAX_PERIOD_CYC = 16667,
    parameter int PEAK_W         = 8,
    localparam int ON_W          = $clog2(MAX_ON_CYC + 1),
    localparam int PER_W         = $clog2(MAX_PERIOD_CYC + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              sense_over,
    input  logic              zcd_low,
    input  logic [PEAK_W-1:0] peak_code,
    output logic              gate,
    output logic [PEAK_W-1:0] peak_ref,
    output logic              cycle_done,
    output logic [ON_W-1:0]   on_time,
    output logic [PER_W-1:0]  demag_time
);

    qrs_state_e state_q;
    qrs_state_e state_d;

    logic              off_req;
    logic [ON_W-1:0]   width_q;
    logic              valley;
    logic [PER_W-1:0]  demag_now;
    logic              min_ok;
    logic              force_start;
    logic              start;
    logic              in_idle;
    logic              in_conduct;
    logic              in_demag;

    assign in_idle    = (state_q == ST_IDLE);
    assign in_conduct = (state_q == ST_CONDUCT);
    assign in_demag   = (state_q == ST_DEMAG);
    assign start      = (state_d == ST_CONDUCT) && !in_conduct;

    qrs_on_timer #(
        .BLANK_CYC (BLANK_CYC),
        .MIN_ON_CYC(MIN_ON_CYC),
        .MAX_ON_CYC(MAX_ON_CYC),
        .W         (ON_W)
    ) u_on (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (start || in_idle),
        .run    (in_conduct),
        .sense  (sense_over),
        .off_req(off_req),
        .width_q(width_q)
    );

    qrs_demag_timer #(
        .ZCD_BLANK_CYC(ZCD_BLANK_CYC),
        .W            (PER_W)
    ) u_demag (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (in_conduct || in_idle),
        .run      (in_demag),
        .zcd      (zcd_low),
        .valley   (valley),
        .demag_now(demag_now)
    );

    qrs_period_timer #(
        .MIN_PERIOD_CYC(MIN_PERIOD_CYC),
        .MAX_PERIOD_CYC(MAX_PERIOD_CYC),
        .W             (PER_W)
    ) u_period (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (start || in_idle),
        .run        (!in_idle),
        .min_ok     (min_ok),
        .force_start(force_start)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (en) state_d = ST_CONDUCT;
            end
            ST_CONDUCT: begin
                if (!en)          state_d = ST_IDLE;
                else if (off_req) state_d = ST_DEMAG;
            end
            ST_DEMAG: begin
                if (!en)                                  state_d = ST_IDLE;
                else if ((valley && min_ok) || force_start) state_d = ST_CONDUCT;
                else if (valley)                          state_d = ST_HOLD;
            end
            ST_HOLD: begin
                if (!en)                       state_d = ST_IDLE;
                else if (min_ok || force_start) state_d = ST_CONDUCT;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gate       <= 1'b0;
            peak_ref   <= '0;
            cycle_done <= 1'b0;
            on_time    <= '0;
            demag_time <= '0;
        end else begin
            gate       <= (state_d == ST_CONDUCT);
            cycle_done <= start && !in_idle;
            if (start) begin
                peak_ref <= peak_code;
            end
            if (start && !in_idle) begin
                on_time    <= width_q;
                demag_time <= demag_now;
            end
        end
    end

endmodule

// File: rtl/qrs_chk.sv
module qrs_chk #(
    parameter int MIN_ON_CYC     = 55,
    parameter int MAX_ON_CYC     = 1280,
    parameter int MIN_PERIOD_CYC = 500,
    parameter int MAX_PERIOD_CYC = 16667,
    parameter int PEAK_W         = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              en,
    input logic              gate,
    input logic              cycle_done,
    input logic [PEAK_W-1:0] peak_ref
);

    logic [15:0] hi_len;
    logic [15:0] per_len;
    logic        gate_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_len  <= '0;
            per_len <= '0;
            gate_d  <= 1'b0;
        end else begin
            gate_d <= gate;
            hi_len <= gate ? ((hi_len == 16'hFFFF) ? hi_len : hi_len + 1'b1) : '0;
            if (gate && !gate_d)          per_len <= 16'd1;
            else if (per_len != 16'hFFFF) per_len <= per_len + 1'b1;
        end
    end

    // R2
    gate_off_when_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !gate);

    // R5
    min_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(gate) && $past(en)) |-> (hi_len >= 16'(MIN_ON_CYC)));

    // R6
    max_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gate |-> (hi_len < 16'(MAX_ON_CYC)));

    // R9
    min_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_done |-> (per_len >= 16'(MIN_PERIOD_CYC)));

    // R11
    max_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_done |-> (per_len <= 16'(MAX_PERIOD_CYC)));

    // R12
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_done |=> !cycle_done);

    // R12
    done_at_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_done |-> (gate && !gate_d));

    // R13
    peak_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gate && gate_d) |-> $stable(peak_ref));

endmodule

bind qr_switch_ctrl qrs_chk #(
    .MIN_ON_CYC    (MIN_ON_CYC),
    .MAX_ON_CYC    (MAX_ON_CYC),
    .MIN_PERIOD_CYC(MIN_PERIOD_CYC),
    .MAX_PERIOD_CYC(MAX_PERIOD_CYC),
    .PEAK_W        (PEAK_W)
) u_qrs_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .gate      (gate),
    .cycle_done(cycle_done),
    .peak_ref  (peak_ref)
);

// File: tb/tb_qr_switch_ctrl.sv
module tb_qr_switch_ctrl;

    localparam int BLANK  = 55;
    localparam int MINON  = 55;
    localparam int MAXON  = 1280;
    localparam int ZB     = 200;
    localparam int MINP   = 500;
    localparam int MAXP   = 16667;
    localparam int NEVER  = 1 << 30;
    localparam int WDOG   = 190000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic        sense_over = 1'b0;
    logic        zcd_low = 1'b0;
    logic [7:0]  peak_code = 8'h00;
    logic        gate;
    logic [7:0]  peak_ref;
    logic        cycle_done;
    logic [10:0] on_time;
    logic [14:0] demag_time;

    always #2 clk = ~clk;

    qr_switch_ctrl dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .sense_over(sense_over),
        .zcd_low   (zcd_low),
        .peak_code (peak_code),
        .gate      (gate),
        .peak_ref  (peak_ref),
        .cycle_done(cycle_done),
        .on_time   (on_time),
        .demag_time(demag_time)
    );

    int checks = 0;
    int fails  = 0;

    task automatic check_eq(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // ---------------- stimulus shaping from observed gate ----------------
    int s_at = NEVER, sg0 = 0, sg1 = 0;
    int z_at = NEVER, zg0 = 0, zg1 = 0;
    int hidx = 0, lidx = 0;
    logic prev_g = 1'b0;

    always @(negedge clk) begin
        if (gate && !prev_g) hidx = 0;
        if (!gate && prev_g) lidx = 0;
        if (gate) begin
            sense_over = (hidx >= s_at) || (hidx >= sg0 && hidx < sg1);
            zcd_low    = 1'b0;
            hidx++;
        end else begin
            sense_over = 1'b0;
            zcd_low    = (lidx >= z_at) || (lidx >= zg0 && lidx < zg1);
            lidx++;
        end
        prev_g = gate;
    end

    // ---------------- behavioural reference model ----------------
    int m_ph = 0, hi = 0, lo = 0, since = 0, lw = 0, dmv = 0;
    bit trip = 0, vseen = 0, go = 0;
    bit m_gate = 0, m_done = 0;
    int m_on = 0, m_dm = 0, m_ref = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; hi = 0; lo = 0; since = 0; lw = 0; dmv = 0;
            trip = 0; vseen = 0; m_gate = 0; m_done = 0;
            m_on = 0; m_dm = 0; m_ref = 0;
        end else begin
            m_done = 0;
            go = 0;
            if (!en) begin
                m_ph = 0;
            end else begin
                case (m_ph)
                    0: go = 1;
                    1: begin
                        if (sense_over && hi >= BLANK) trip = 1;
                        if ((trip && hi + 1 >= MINON) || hi + 1 >= MAXON) begin
                            lw = hi + 1; lo = 0; dmv = 0; vseen = 0; m_ph = 2;
                        end else begin
                            hi++;
                        end
                        since++;
                    end
                    2: begin
                        if (zcd_low && lo >= ZB) begin dmv = lo + 1; vseen = 1; end
                        lo++;
                        if ((vseen && since + 1 >= MINP) || since + 1 >= MAXP) go = 1;
                        else begin
                            if (vseen) m_ph = 3;
                            since++;
                        end
                    end
                    default: begin
                        if (since + 1 >= MINP) go = 1;
                        else since++;
                    end
                endcase
            end
            if (go) begin
                if (m_ph != 0) begin m_done = 1; m_on = lw; m_dm = dmv; end
                m_ph = 1; hi = 0; since = 0; trip = 0; m_ref = peak_code;
            end
            m_gate = (m_ph == 1);
        end
    end

    // every-cycle comparison against the model
    int cyc = 0, ndone = 0, last_on = 0, last_dm = 0, last_rise = 0, last_period = 0;
    logic g_seen = 1'b0;

    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            check_eq("R4 gate vs model", gate, m_gate);
            check_eq("R12 cycle_done vs model", cycle_done, m_done);
            check_eq("R13 peak_ref vs model", peak_ref, m_ref);
            if (cycle_done) begin
                check_eq("R12 on_time vs model", on_time, m_on);
                check_eq("R8 demag_time vs model", demag_time, m_dm);
                ndone++;
                last_on = on_time;
                last_dm = demag_time;
            end
            if (gate && !g_seen) begin
                last_period = cyc - last_rise;
                last_rise = cyc;
            end
        end
        g_seen = gate;
    end

    task automatic wait_dones(int n);
        int target;
        target = ndone + n;
        while (ndone < target) begin
            @(negedge clk);
            #1;
        end
    endtask

    task automatic wait_cycles(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
        #1;
    endtask

    // watchdog
    initial begin
        wait_cycles(WDOG);
        fails++;
        checks++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", WDOG);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int nd;
        // R1: reset state
        wait_cycles(5);
        check_eq("R1 gate in reset", gate, 0);
        check_eq("R1 done in reset", cycle_done, 0);
        @(negedge clk) rst_n = 1'b1;
        wait_cycles(1);
        check_eq("R1 gate after reset", gate, 0);
        check_eq("R1 on_time after reset", on_time, 0);
        check_eq("R1 demag_time after reset", demag_time, 0);
        check_eq("R1 peak_ref after reset", peak_ref, 0);

        // R4, R8, R9: trip at index 100, valley at 200 -> Hold until 500
        peak_code = 8'h40;
        s_at = 100; z_at = 200;
        en = 1'b1;
        wait_dones(2);
        check_eq("R4 on_time for trip at 100", last_on, 101);
        check_eq("R8 demag_time at first unblanked ZCD", last_dm, 201);
        check_eq("R9 period clamped to minimum", last_period, MINP);
        check_eq("R13 peak_ref captured", peak_ref, 8'h40);

        // R13: change peak_code mid-pulse
        while (!gate) @(negedge clk);
        wait_cycles(5);
        peak_code = 8'h55;
        wait_cycles(3);
        check_eq("R13 peak_ref held during pulse", peak_ref, 8'h40);
        wait_dones(1);
        check_eq("R13 peak_ref updated at start", peak_ref, 8'h55);

        // R5: sense held high from the start
        s_at = 0;
        wait_dones(2);
        check_eq("R5 minimum on-time with sense always high", last_on, BLANK + 1);

        // R3: sense glitch inside blanking only
        s_at = 300; sg0 = 10; sg1 = 40;
        wait_dones(2);
        check_eq("R3 blanked sense ignored", last_on, 301);
        sg0 = 0; sg1 = 0;

        // R6: no trip
        s_at = NEVER;
        wait_dones(2);
        check_eq("R6 forced off at max on-time", last_on, MAXON);

        // R7, R10: late valley, blanked ZCD glitch
        s_at = 1000; z_at = 400; zg0 = 20; zg1 = 60;
        wait_dones(2);
        check_eq("R7 blanked ZCD ignored", last_dm, 401);
        check_eq("R10 period is on plus demag", last_period, 1001 + 401);

        // R11: no valley at all
        z_at = NEVER; zg0 = 10; zg1 = 20;
        wait_dones(2);
        check_eq("R11 forced start period", last_period, MAXP);
        check_eq("R8 demag_time zero without valley", last_dm, 0);
        zg0 = 0; zg1 = 0;

        // R2: enable drop mid-pulse and re-enable
        s_at = 100; z_at = 200;
        wait_dones(1);
        wait_cycles(10);
        check_eq("R2 gate high before disable", gate, 1);
        en = 1'b0;
        nd = ndone;
        wait_cycles(1);
        check_eq("R2 gate low one clock after disable", gate, 0);
        wait_cycles(20);
        check_eq("R2 no strobe while disabled", ndone, nd);
        en = 1'b1;
        wait_cycles(1);
        check_eq("R2 gate rises on re-enable", gate, 1);
        check_eq("R12 no strobe on first pulse", ndone, nd);
        wait_dones(1);
        check_eq("R12 strobe after first full cycle", last_on, 101);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule